// File: doc/BRIEF.md
# Processor State and Exception Sequencer

This block is the top-level control sequencer of a small 32-bit processor. It decides which operating state the processor is in: held in reset, running an exception entry, executing, powered down, or with the bus handed to another master. It also performs the memory transactions that belong to those transitions. After reset it loads the start address and the initial stack pointer from the vector table. On interrupt entry it stacks the status and the return address, then fetches the service routine address.

Instruction execution is reduced to a single execution state, where a `step` pulse advances the program counter by one instruction. The sequencer owns the program counter, the stack pointer and the status register and presents them as outputs. A simple memory port with separate read and write strobes and a `mem_ready` handshake connects it to memory. A bus grant output lets an external master take the bus. Both reset inputs are sampled on the clock.

Fine states and transitions: `SQ_RESET` moves to `SQ_VEC_PC` once both resets are low. `SQ_VEC_PC` moves to `SQ_VEC_SP`, and `SQ_VEC_SP` moves to `SQ_EXEC`, each on ready. `SQ_EXEC` can move to `SQ_PUSH_SR` on an interrupt, to `SQ_BUSREL` on a bus request, or to `SQ_PDOWN` on a sleep request, and it stays put on a step. `SQ_PUSH_SR` moves to `SQ_PUSH_PC`, then `SQ_VEC_IRQ`, then back to `SQ_EXEC`, each on ready. `SQ_PDOWN` can move to `SQ_PUSH_SR` on a wake interrupt, or to `SQ_BUSREL` from sleep mode. `SQ_BUSREL` returns to the state it left. Any reset forces `SQ_RESET` from every state.

Top module: `cpu_state_seq`

## Requirements
- R1: When `por_rst` or `man_rst` is high at a clock edge, the next cycle shows the reset state. In that state `pc` = 0, `sp` = 0, `sr` = SR_INIT (0x000000F0), `pd_mode` = 0, `bus_grant` = 0 and no memory strobe is active. This holds from any state, including in the middle of a memory access.
- R2: `man_rst_flag` becomes 1 after a reset in which only `man_rst` was high. It becomes 0 after any reset with `por_rst` high, even when `man_rst` is also high, because power-on takes priority. The flag keeps its value until the next reset.
- R3: After reset is released, the block reads address 0x0 and loads the word into `pc`. It then reads address 0x4 and loads the word into `sp`, and then enters execution.
- R4: A memory access holds its strobe, address and write data unchanged until `mem_ready` is sampled high. The sequencer does not advance before that edge.
- R5: On an accepted interrupt, the block first writes `sr` to SP-4, then writes `pc` to SP-8. SP drops by 4 at each completed write. It then reads the vector from address 4*`irq_vec` into `pc` and returns to execution.
- R6: In execution the priority is interrupt, then bus request, then sleep request, then step. A step that wins advances `pc` by 4.
- R7: A sleep request enters power-down and records the mode in `pd_mode`, encoded as 1 = sleep, 2 = software standby and 3 = deep standby. A requested mode of 0 is recorded as 1. `pd_mode` reads 0 during execution.
- R8: Sleep wakes on any interrupt. Software standby wakes only when `irq_wake` is high with the interrupt. Deep standby ignores interrupts and bus requests and leaves only through reset. Every wake runs the interrupt entry of R5 and clears `pd_mode`.
- R9: A bus request is granted only from execution or from sleep mode, on the next edge, and never during a memory access. `bus_grant` is high exactly in the bus-released state, and no strobe is active there.
- R10: One edge after `bus_req` is sampled low in the bus-released state, `bus_grant` drops. The block returns to the state it left, with `pd_mode` kept when that state was sleep.
- R11: `top_state` encodes reset = 0, exception handling (vector fetch and stacking) = 1, execution = 2, power-down = 3, bus-released = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, active high, sampled |
| man_rst | input | 1 | Manual reset, active high, sampled |
| irq_req | input | 1 | Interrupt request, already arbitrated |
| irq_vec | input | VEC_W | Vector number of the request |
| irq_wake | input | 1 | Request may wake software standby |
| sleep_req | input | 1 | Enter power-down |
| sleep_mode | input | 2 | Requested power-down mode |
| step | input | 1 | Advance PC by one instruction |
| bus_req | input | 1 | External master requests the bus |
| mem_addr | output | DATA_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ready | input | 1 | Access completes at this edge |
| bus_grant | output | 1 | Bus handed to external master |
| top_state | output | 3 | Coarse operating state |
| pd_mode | output | 2 | Recorded power-down mode |
| man_rst_flag | output | 1 | Last reset was manual only |
| pc | output | DATA_W | Program counter |
| sp | output | DATA_W | Stack pointer |
| sr | output | DATA_W | Status register |

## Verification
The bench raises an interrupt and a bus request in the same execution cycle. The interrupt must win, and the grant must stay low through the stacking writes and the vector read. The bus-released state may follow only once execution is reached. Two further collisions are driven: a step in the same cycle as an interrupt, where the step must be lost, and a manual reset while a stack write waits for ready. A behavioural model is advanced with the same inputs, and every output is compared against it in every cycle. Directed checks at the end of each sequence look at the stacked words, the final PC and SP, and the grant timing.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

    typedef enum logic [3:0] {
        SQ_RESET,
        SQ_VEC_PC,
        SQ_VEC_SP,
        SQ_PUSH_SR,
        SQ_PUSH_PC,
        SQ_VEC_IRQ,
        SQ_EXEC,
        SQ_PDOWN,
        SQ_BUSREL
    } seq_state_e;

    typedef enum logic [2:0] {
        TOP_RESET  = 3'd0,
        TOP_EXCEPT = 3'd1,
        TOP_EXEC   = 3'd2,
        TOP_PDOWN  = 3'd3,
        TOP_BUSREL = 3'd4
    } top_state_e;

    localparam logic [1:0] PD_NONE  = 2'd0;
    localparam logic [1:0] PD_SLEEP = 2'd1;
    localparam logic [1:0] PD_SSTBY = 2'd2;
    localparam logic [1:0] PD_DEEP  = 2'd3;

    typedef struct packed {
        logic ld_pc;
        logic ld_sp;
        logic dec_sp;
        logic step_pc;
        logic cap_vec;
        logic set_pd;
        logic clr_pd;
    } seq_act_t;

endpackage

// File: rtl/cpu_seq_fsm.sv
module cpu_seq_fsm
    import cpu_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_any,
    input  logic       irq_req,
    input  logic       irq_wake,
    input  logic       sleep_req,
    input  logic       step,
    input  logic       bus_req,
    input  logic       mem_ready,
    input  logic [1:0] pd_mode,
    output seq_state_e state_q,
    output seq_act_t   act
);

    seq_state_e state_d;
    seq_state_e ret_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            state_q <= SQ_RESET;
            ret_q   <= SQ_EXEC;
        end else begin
            state_q <= state_d;
            if (state_d == SQ_BUSREL && state_q != SQ_BUSREL) begin
                ret_q <= state_q;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        act     = '0;
        unique case (state_q)
            SQ_RESET: state_d = SQ_VEC_PC;
            SQ_VEC_PC: begin
                if (mem_ready) begin
                    act.ld_pc = 1'b1;
                    state_d   = SQ_VEC_SP;
                end
            end
            SQ_VEC_SP: begin
                if (mem_ready) begin
                    act.ld_sp = 1'b1;
                    state_d   = SQ_EXEC;
                end
            end
            SQ_PUSH_SR: begin
                if (mem_ready) begin
                    act.dec_sp = 1'b1;
                    state_d    = SQ_PUSH_PC;
                end
            end
            SQ_PUSH_PC: begin
                if (mem_ready) begin
                    act.dec_sp = 1'b1;
                    state_d    = SQ_VEC_IRQ;
                end
            end
            SQ_VEC_IRQ: begin
                if (mem_ready) begin
                    act.ld_pc = 1'b1;
                    state_d   = SQ_EXEC;
                end
            end
            SQ_EXEC: begin
                if (irq_req) begin
                    act.cap_vec = 1'b1;
                    state_d     = SQ_PUSH_SR;
                end else if (bus_req) begin
                    state_d = SQ_BUSREL;
                end else if (sleep_req) begin
                    act.set_pd = 1'b1;
                    state_d    = SQ_PDOWN;
                end else if (step) begin
                    act.step_pc = 1'b1;
                end
            end
            SQ_PDOWN: begin
                case (pd_mode)
                    PD_SLEEP: begin
                        if (irq_req) begin
                            act.cap_vec = 1'b1;
                            act.clr_pd  = 1'b1;
                            state_d     = SQ_PUSH_SR;
                        end else if (bus_req) begin
                            state_d = SQ_BUSREL;
                        end
                    end
                    PD_SSTBY: begin
                        if (irq_req && irq_wake) begin
                            act.cap_vec = 1'b1;
                            act.clr_pd  = 1'b1;
                            state_d     = SQ_PUSH_SR;
                        end
                    end
                    default: state_d = SQ_PDOWN;
                endcase
            end
            SQ_BUSREL: begin
                if (!bus_req) begin
                    state_d = ret_q;
                end
            end
            default: state_d = SQ_RESET;
        endcase
    end

endmodule

// File: rtl/cpu_seq_regs.sv
module cpu_seq_regs
    import cpu_seq_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter int              VEC_W      = 8,
    parameter int              STEP_BYTES = 4,
    parameter logic [DATA_W-1:0] SR_INIT  = 32'h0000_00F0
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              man_rst,
    input  seq_act_t          act,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [1:0]        sleep_mode,
    output logic [DATA_W-1:0] pc_q,
    output logic [DATA_W-1:0] sp_q,
    output logic [DATA_W-1:0] sr_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic [1:0]        pd_q,
    output logic              man_flag_q
);

    localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);
    localparam logic [DATA_W-1:0] STEP_INC   = DATA_W'(STEP_BYTES);

    logic [1:0] pd_req;
    assign pd_req = (sleep_mode == PD_NONE) ? PD_SLEEP : sleep_mode;

    always_ff @(posedge clk) begin
        if (por_rst || man_rst) begin
            pc_q       <= '0;
            sp_q       <= '0;
            sr_q       <= SR_INIT;
            vec_q      <= '0;
            pd_q       <= PD_NONE;
            man_flag_q <= man_rst && !por_rst;
        end else begin
            if (act.ld_pc)   pc_q  <= mem_rdata;
            if (act.step_pc) pc_q  <= pc_q + STEP_INC;
            if (act.ld_sp)   sp_q  <= mem_rdata;
            if (act.dec_sp)  sp_q  <= sp_q - WORD_BYTES;
            if (act.cap_vec) vec_q <= irq_vec;
            if (act.set_pd)  pd_q  <= pd_req;
            if (act.clr_pd)  pd_q  <= PD_NONE;
        end
    end

endmodule

// File: rtl/cpu_seq_memport.sv
module cpu_seq_memport
    import cpu_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  seq_state_e        state_q,
    input  logic [DATA_W-1:0] pc_q,
    input  logic [DATA_W-1:0] sp_q,
    input  logic [DATA_W-1:0] sr_q,
    input  logic [VEC_W-1:0]  vec_q,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              bus_grant,
    output logic [2:0]        top_state
);

    localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);

    logic [DATA_W-1:0] vec_addr;
    logic [DATA_W-1:0] push_addr;

    always_comb begin
        vec_addr = '0;
        vec_addr[VEC_W+1:0] = {vec_q, 2'b00};
    end

    assign push_addr = sp_q - WORD_BYTES;

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        bus_grant = 1'b0;
        top_state = TOP_RESET;
        unique case (state_q)
            SQ_RESET: top_state = TOP_RESET;
            SQ_VEC_PC: begin
                top_state = TOP_EXCEPT;
                mem_rd    = 1'b1;
            end
            SQ_VEC_SP: begin
                top_state = TOP_EXCEPT;
                mem_rd    = 1'b1;
                mem_addr  = WORD_BYTES;
            end
            SQ_PUSH_SR: begin
                top_state = TOP_EXCEPT;
                mem_wr    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = sr_q;
            end
            SQ_PUSH_PC: begin
                top_state = TOP_EXCEPT;
                mem_wr    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = pc_q;
            end
            SQ_VEC_IRQ: begin
                top_state = TOP_EXCEPT;
                mem_rd    = 1'b1;
                mem_addr  = vec_addr;
            end
            SQ_EXEC:   top_state = TOP_EXEC;
            SQ_PDOWN:  top_state = TOP_PDOWN;
            SQ_BUSREL: begin
                top_state = TOP_BUSREL;
                bus_grant = 1'b1;
            end
            default: top_state = TOP_RESET;
        endcase
    end

endmodule

// File: rtl/cpu_state_seq.sv
module cpu_state_seq
    import cpu_seq_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                VEC_W      = 8,
    parameter int                STEP_BYTES = 4,
    parameter logic [DATA_W-1:0] SR_INIT    = 32'h0000_00F0
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              man_rst,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              irq_wake,
    input  logic              sleep_req,
    input  logic [1:0]        sleep_mode,
    input  logic              step,
    input  logic              bus_req,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              bus_grant,
    output logic [2:0]        top_state,
    output logic [1:0]        pd_mode,
    output logic              man_rst_flag,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] sr
);

    seq_state_e       state_q;
    seq_act_t         act;
    logic [VEC_W-1:0] vec_q;
    logic             rst_any;

    assign rst_any = por_rst || man_rst;

    cpu_seq_fsm u_fsm (
        .clk       (clk),
        .rst_any   (rst_any),
        .irq_req   (irq_req),
        .irq_wake  (irq_wake),
        .sleep_req (sleep_req),
        .step      (step),
        .bus_req   (bus_req),
        .mem_ready (mem_ready),
        .pd_mode   (pd_mode),
        .state_q   (state_q),
        .act       (act)
    );

    cpu_seq_regs #(
        .DATA_W     (DATA_W),
        .VEC_W      (VEC_W),
        .STEP_BYTES (STEP_BYTES),
        .SR_INIT    (SR_INIT)
    ) u_regs (
        .clk        (clk),
        .por_rst    (por_rst),
        .man_rst    (man_rst),
        .act        (act),
        .mem_rdata  (mem_rdata),
        .irq_vec    (irq_vec),
        .sleep_mode (sleep_mode),
        .pc_q       (pc),
        .sp_q       (sp),
        .sr_q       (sr),
        .vec_q      (vec_q),
        .pd_q       (pd_mode),
        .man_flag_q (man_rst_flag)
    );

    cpu_seq_memport #(
        .DATA_W (DATA_W),
        .VEC_W  (VEC_W)
    ) u_mem (
        .state_q   (state_q),
        .pc_q      (pc),
        .sp_q      (sp),
        .sr_q      (sr),
        .vec_q     (vec_q),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .bus_grant (bus_grant),
        .top_state (top_state)
    );

endmodule

// File: rtl/cpu_state_seq_chk.sv
module cpu_state_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              por_rst,
    input logic              man_rst,
    input logic              bus_req,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_addr,
    input logic              bus_grant,
    input logic [2:0]        top_state,
    input logic [1:0]        pd_mode,
    input logic              man_rst_flag,
    input logic [DATA_W-1:0] pc,
    input logic [DATA_W-1:0] sp
);

    a_r1_reset_forces: assert property (@(posedge clk)
        (por_rst || man_rst) |=> (top_state == 3'd0 && pc == '0 && !bus_grant && !mem_rd && !mem_wr));

    a_r2_por_clears_flag: assert property (@(posedge clk)
        por_rst |=> !man_rst_flag);

    a_r4_hold_access: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        ((mem_rd || mem_wr) && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr)));

    a_r5_push_dec: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        (mem_wr && mem_ready) |=> (sp == $past(sp) - DATA_W'(4)));

    a_r7_exec_no_pd: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        (top_state == 3'd2) |-> (pd_mode == 2'd0));

    a_r8_deep_holds: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        (top_state == 3'd3 && pd_mode == 2'd3) |=> (top_state == 3'd3 && pd_mode == 2'd3));

    a_r9_grant_quiet: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        bus_grant |-> (!mem_rd && !mem_wr));

    a_r9_grant_origin: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        $rose(bus_grant) |-> ($past(top_state) == 3'd2 || ($past(top_state) == 3'd3 && $past(pd_mode) == 2'd1)));

    a_r10_grant_drop: assert property (@(posedge clk) disable iff (por_rst || man_rst)
        (bus_grant && !bus_req) |=> !bus_grant);

endmodule

bind cpu_state_seq cpu_state_seq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .por_rst      (por_rst),
    .man_rst      (man_rst),
    .bus_req      (bus_req),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .bus_grant    (bus_grant),
    .top_state    (top_state),
    .pd_mode      (pd_mode),
    .man_rst_flag (man_rst_flag),
    .pc           (pc),
    .sp           (sp)
);

// File: tb/cpu_state_seq_tb_top.sv
module cpu_state_seq_tb_top;

    localparam logic [31:0] SR_INIT = 32'h0000_00F0;
    localparam int P_RST = 0, P_VPC = 1, P_VSP = 2, P_PSR = 3, P_PPC = 4,
                   P_VIRQ = 5, P_EXEC = 6, P_PD = 7, P_BR = 8;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1, man_rst = 1'b0;
    logic        irq_req = 1'b0, irq_wake = 1'b0, sleep_req = 1'b0, step = 1'b0, bus_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic [1:0]  sleep_mode = '0;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, pc, sp, sr;
    logic        mem_rd, mem_wr, bus_grant, man_rst_flag;
    logic [2:0]  top_state;
    logic [1:0]  pd_mode;

    int n_tests = 0, n_fail = 0, cycles = 0, lat = 1, wait_cnt = 0;
    logic [31:0] stk [logic [31:0]];

    // behavioural reference state
    int          ph = P_RST, mret = P_EXEC;
    logic [31:0] mpc = '0, msp = '0, msr = SR_INIT;
    logic [7:0]  mvec = '0;
    logic [1:0]  mpd = '0;
    logic        mflag = 1'b0;

    always #10 clk = ~clk;

    cpu_state_seq dut_i (
        .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_wake(irq_wake), .sleep_req(sleep_req),
        .sleep_mode(sleep_mode), .step(step), .bus_req(bus_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .bus_grant(bus_grant),
        .top_state(top_state), .pd_mode(pd_mode), .man_rst_flag(man_rst_flag),
        .pc(pc), .sp(sp), .sr(sr)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        if (a == 32'h0) return 32'h0000_0100;
        if (a == 32'h4) return 32'h0000_8000;
        return 32'h0000_4000 + a;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model: advances on the same sampled inputs
    always @(posedge clk) begin
        cycles++;
        if (por_rst || man_rst) begin
            ph = P_RST; mpc = '0; msp = '0; msr = SR_INIT; mvec = '0; mpd = '0;
            mflag = !por_rst && man_rst; mret = P_EXEC;
        end else begin
            case (ph)
                P_RST:  ph = P_VPC;
                P_VPC:  if (mem_ready) begin mpc = memval(32'h0); ph = P_VSP; end
                P_VSP:  if (mem_ready) begin msp = memval(32'h4); ph = P_EXEC; end
                P_PSR:  if (mem_ready) begin msp = msp - 4; ph = P_PPC; end
                P_PPC:  if (mem_ready) begin msp = msp - 4; ph = P_VIRQ; end
                P_VIRQ: if (mem_ready) begin mpc = memval({22'd0, mvec, 2'b00}); ph = P_EXEC; end
                P_EXEC: begin
                    if (irq_req) begin mvec = irq_vec; ph = P_PSR; end
                    else if (bus_req) begin mret = P_EXEC; ph = P_BR; end
                    else if (sleep_req) begin mpd = (sleep_mode == 2'd0) ? 2'd1 : sleep_mode; ph = P_PD; end
                    else if (step) mpc = mpc + 4;
                end
                P_PD: begin
                    if ((mpd == 2'd1 && irq_req) || (mpd == 2'd2 && irq_req && irq_wake)) begin
                        mvec = irq_vec; mpd = '0; ph = P_PSR;
                    end else if (mpd == 2'd1 && bus_req) begin
                        mret = P_PD; ph = P_BR;
                    end
                end
                P_BR: if (!bus_req) ph = mret;
                default: ph = P_RST;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [2:0]  et;
        logic        erd, ewr;
        logic [31:0] ea, ew;
        et = (ph == P_RST) ? 3'd0 : (ph == P_EXEC) ? 3'd2 : (ph == P_PD) ? 3'd3 : (ph == P_BR) ? 3'd4 : 3'd1;
        erd = (ph == P_VPC || ph == P_VSP || ph == P_VIRQ);
        ewr = (ph == P_PSR || ph == P_PPC);
        ea = (ph == P_VSP) ? 32'h4 : (ewr ? msp - 4 : (ph == P_VIRQ) ? {22'd0, mvec, 2'b00} : 32'h0);
        ew = (ph == P_PSR) ? msr : mpc;
        chk("R11 top_state", {29'd0, top_state}, {29'd0, et});
        chk("R6 pc", pc, mpc);
        chk("R5 sp", sp, msp);
        chk("R1 sr", sr, msr);
        chk("R7 pd_mode", {30'd0, pd_mode}, {30'd0, mpd});
        chk("R2 man_rst_flag", {31'd0, man_rst_flag}, {31'd0, mflag});
        chk("R9 bus_grant", {31'd0, bus_grant}, {31'd0, (ph == P_BR)});
        chk("R4 strobes", {30'd0, mem_rd, mem_wr}, {30'd0, erd, ewr});
        if (erd || ewr) chk("R4 mem_addr", mem_addr, ea);
        if (ewr) chk("R5 mem_wdata", mem_wdata, ew);
    end

    // memory responder with programmable latency
    always @(negedge clk) begin
        if (mem_rd || mem_wr) begin
            if (wait_cnt >= lat) begin
                mem_ready = 1'b1;
                mem_rdata = memval(mem_addr);
                if (mem_wr) stk[mem_addr] = mem_wdata;
                wait_cnt = 0;
            end else begin
                mem_ready = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wait_cnt  = 0;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_top(input logic [2:0] code, input string req);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (top_state == code) return;
        end
        chk(req, {29'd0, top_state}, {29'd0, code});
    endtask

    task automatic enter_pd(input logic [1:0] mode);
        sleep_req = 1'b1; sleep_mode = mode;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    initial begin
        // R1 reset and R3 vector fetch
        repeat (3) @(negedge clk);
        chk("R1 reset top", {29'd0, top_state}, 32'd0);
        chk("R1 reset pc", pc, 32'h0);
        chk("R1 reset sr", sr, SR_INIT);
        por_rst = 1'b0;
        wait_top(3'd2, "R3 reach exec");
        chk("R3 pc from 0x0", pc, 32'h100);
        chk("R3 sp from 0x4", sp, 32'h8000);

        // R6 steps
        step = 1'b1;
        repeat (3) @(negedge clk);
        step = 1'b0;
        chk("R6 three steps", pc, 32'h10C);

        // R5 + R9: interrupt and bus request in the same cycle
        lat = 2;
        irq_req = 1'b1; irq_vec = 8'd5; bus_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        chk("R9 no grant during entry", {31'd0, bus_grant}, 32'd0);
        wait_top(3'd4, "R9 grant after entry");
        chk("R5 stacked sr", stk[32'h7FFC], SR_INIT);
        chk("R5 stacked pc", stk[32'h7FF8], 32'h10C);
        chk("R5 sp after push", sp, 32'h7FF8);
        chk("R5 pc from vector", pc, 32'h4014);
        bus_req = 1'b0;
        @(negedge clk);
        chk("R10 back to exec", {29'd0, top_state}, 32'd2);
        chk("R10 grant dropped", {31'd0, bus_grant}, 32'd0);

        // R7 sleep mode 0 -> 1, R9/R10 bus release from sleep, R8 wake
        lat = 0;
        enter_pd(2'd0);
        chk("R7 pd sleep", {30'd0, pd_mode}, 32'd1);
        bus_req = 1'b1;
        @(negedge clk);
        chk("R9 grant from sleep", {29'd0, top_state}, 32'd4);
        bus_req = 1'b0;
        @(negedge clk);
        chk("R10 back to sleep", {29'd0, top_state}, 32'd3);
        chk("R10 pd kept", {30'd0, pd_mode}, 32'd1);
        irq_req = 1'b1; irq_vec = 8'd9; irq_wake = 1'b0;
        @(negedge clk);
        irq_req = 1'b0;
        chk("R8 sleep wakes", {29'd0, top_state}, 32'd1);
        wait_top(3'd2, "R8 exec after wake");
        chk("R8 pc after wake", pc, 32'h4024);

        // R8 software standby
        enter_pd(2'd2);
        chk("R7 pd sstby", {30'd0, pd_mode}, 32'd2);
        irq_req = 1'b1; bus_req = 1'b1;
        repeat (2) @(negedge clk);
        irq_req = 1'b0; bus_req = 1'b0;
        chk("R8 sstby ignores plain irq", {29'd0, top_state}, 32'd3);
        irq_req = 1'b1; irq_wake = 1'b1;
        @(negedge clk);
        irq_req = 1'b0; irq_wake = 1'b0;
        chk("R8 sstby wake irq", {29'd0, top_state}, 32'd1);
        wait_top(3'd2, "R8 exec after sstby");

        // R8 deep standby, R2 reset kinds
        enter_pd(2'd3);
        chk("R7 pd deep", {30'd0, pd_mode}, 32'd3);
        irq_req = 1'b1; irq_wake = 1'b1; bus_req = 1'b1; step = 1'b1;
        repeat (3) @(negedge clk);
        irq_req = 1'b0; irq_wake = 1'b0; bus_req = 1'b0; step = 1'b0;
        chk("R8 deep stays", {29'd0, top_state}, 32'd3);
        chk("R8 deep no grant", {31'd0, bus_grant}, 32'd0);
        man_rst = 1'b1;
        @(negedge clk);
        chk("R1 manual reset top", {29'd0, top_state}, 32'd0);
        chk("R2 manual flag", {31'd0, man_rst_flag}, 32'd1);
        man_rst = 1'b0;
        wait_top(3'd2, "R3 exec after manual");
        chk("R2 flag held", {31'd0, man_rst_flag}, 32'd1);
        por_rst = 1'b1; man_rst = 1'b1;
        @(negedge clk);
        chk("R2 por priority", {31'd0, man_rst_flag}, 32'd0);
        por_rst = 1'b0; man_rst = 1'b0;
        wait_top(3'd2, "R3 exec after por");

        // R1 reset during a waiting stack write
        lat = 3;
        irq_req = 1'b1; irq_vec = 8'd3;
        @(negedge clk);
        irq_req = 1'b0;
        @(negedge clk);
        chk("R4 write pending", {31'd0, mem_wr}, 32'd1);
        man_rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid access", {29'd0, top_state}, 32'd0);
        chk("R1 no write in reset", {31'd0, mem_wr}, 32'd0);
        man_rst = 1'b0;
        lat = 1;
        wait_top(3'd2, "R3 exec after mid reset");

        // R6 step loses to interrupt
        irq_req = 1'b1; irq_vec = 8'd2; step = 1'b1;
        @(negedge clk);
        irq_req = 1'b0; step = 1'b0;
        wait_top(3'd2, "R6 exec after irq");
        chk("R6 step dropped", pc, 32'h4008);

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule